// File: doc/BRIEF.md
# Packet Framer with Acknowledge Builder

The framer turns a payload held in a small transmit buffer into a serial stream of beats, one bit per beat. Each beat also carries a field tag. A data frame runs through a fixed sequence of fields:

1. A preamble made of a programmable number of units.
2. Two start-of-packet framing symbols, each held for a short or a long programmable beat count.
3. An optional length byte.
4. The payload bytes, fetched one at a time from the buffer.
5. A 16-bit CRC computed over the length and payload bits.

All durations are counted in beats rather than in real time, so one design serves any rate and any test scale.

The second frame type is a short acknowledge. It sends the same preamble and framing symbols, and then the 16-bit check value that a receiver stored through the CRC latch port. An acknowledge has no length byte and no payload.

The downstream consumer paces the stream with a ready/valid handshake and may stall at any beat without losing data. After the last check bit is accepted the framer returns to idle and raises a one-cycle done pulse.

Top module: `pkt_framer`

## Requirements
- R1: After reset the framer is idle: sym_valid=0, sym_kind=0, done=0 and rd_en=0.
- R2: A data frame emits the fields in the order preamble, first framing symbol, second framing symbol, length, payload, check value, with sym_kind codes 1, 2, 3, 4, 5 and 6. Idle is code 0.
- R3: The preamble lasts cfg_pre_units units of cfg_unit_beats beats each, with a beat count of 0 treated as 1. Within each unit, even-numbered beats carry bit 1 and odd-numbered beats carry bit 0. A unit count of zero skips the preamble.
- R4: Each framing symbol lasts cfg_sop_long beats when cfg_sop_sel=1 and cfg_sop_short beats otherwise, with 0 treated as 1. The first symbol carries bit 1 and the second carries bit 0.
- R5: When cfg_len_en=1, the length byte carries the payload byte count (pay_len clamped to MAX_PAY), sent most significant bit first over 8 beats. When cfg_len_en=0, the length byte is omitted.
- R6: Payload bytes are read from buffer addresses 0, 1, 2 and so on in turn, through rd_en, rd_addr and a same-cycle rd_data. Each byte is sent most significant bit first.
- R7: The data frame check value is the CRC with polynomial 0x1021 and seed 0x0000, shifted over every length and payload bit in send order. It is sent as 16 beats, most significant bit first.
- R8: An acknowledge frame sends the preamble and both framing symbols, then the 16 bits last written through rx_crc_we/rx_crc_in, most significant bit first. It has no length or payload beats.
- R9: While sym_valid=1 and sym_ready=0, sym_bit and sym_kind hold their values. The accepted beat sequence does not depend on the ready pattern.
- R10: done is high for exactly one cycle, in the cycle after the last check-value beat is accepted, and sym_valid is 0 in that cycle.
- R11: Start pulses and configuration changes during a frame have no effect on that frame and start no new frame. When start_data and start_ack rise together at idle, a data frame is sent.
- R12: A zero payload count sends no payload beats. With the length byte enabled the check value follows the length byte directly; with it disabled the check value is 0x0000 and follows the second framing symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_pre_units | input | CNT_W | Preamble unit count |
| cfg_unit_beats | input | CNT_W | Beats per preamble unit |
| cfg_sop_short | input | CNT_W | Short framing symbol beat count |
| cfg_sop_long | input | CNT_W | Long framing symbol beat count |
| cfg_sop_sel | input | 1 | Selects the long framing symbol |
| cfg_len_en | input | 1 | Enables the length byte |
| pay_len | input | LEN_W | Payload byte count |
| start_data | input | 1 | Starts a data frame when idle |
| start_ack | input | 1 | Starts an acknowledge frame when idle |
| rx_crc_we | input | 1 | Writes the received check value latch |
| rx_crc_in | input | 16 | Received check value |
| rd_en | output | 1 | Buffer fetch strobe |
| rd_addr | output | ADDR_W | Buffer fetch address |
| rd_data | input | 8 | Buffer byte, valid in the same cycle |
| sym_valid | output | 1 | Beat valid |
| sym_ready | input | 1 | Beat accepted by consumer |
| sym_bit | output | 1 | Beat bit value |
| sym_kind | output | 3 | Field tag of the beat |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest case to reach is a stall that lands exactly on a field or byte boundary. At that beat the framer has already fetched or loaded the next byte, yet the shift register and the CRC must not move until the beat is accepted. The bench drives sym_ready from a random generator in three density modes, so many frames stall at every boundary across varied preamble, framing and payload lengths. A further directed frame pulses both starts and rewrites every configuration input mid-frame, then confirms that the accepted stream still matches the frame as it was configured at start.

// File: rtl/framer_pkg.sv
package framer_pkg;

  typedef enum logic [2:0] {
    K_IDLE = 3'd0,
    K_PRE  = 3'd1,
    K_SOP1 = 3'd2,
    K_SOP2 = 3'd3,
    K_LEN  = 3'd4,
    K_PAY  = 3'd5,
    K_CRC  = 3'd6
  } fld_e;

  // one serial step of the check value register
  function automatic logic [15:0] crc_step(input logic [15:0] cur,
                                           input logic        din,
                                           input logic [15:0] poly);
    logic fb;
    fb = cur[15] ^ din;
    return {cur[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
  endfunction

endpackage

// File: rtl/pkt_crc16.sv
module pkt_crc16
  import framer_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic [15:0] init_val,
  input  logic        absorb,
  input  logic        bit_in,
  input  logic        shift,
  output logic        msb
);

  logic [15:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (init) begin
      word_q <= init_val;
    end else if (absorb) begin
      word_q <= crc_step(word_q, bit_in, POLY);
    end else if (shift) begin
      word_q <= {word_q[14:0], 1'b0};
    end
  end

  assign msb = word_q[15];

  // R7
  absorb_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    absorb |-> !shift);

endmodule

// File: rtl/pkt_byte_ser.sv
module pkt_byte_ser (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_len,
  input  logic [7:0] len_val,
  input  logic       ld_pay,
  input  logic [7:0] pay_byte,
  input  logic       shift_en,
  output logic       bit_out
);

  logic [7:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (ld_len) begin
      sh_q <= len_val;
    end else if (ld_pay) begin
      sh_q <= pay_byte;
    end else if (shift_en) begin
      sh_q <= {sh_q[6:0], 1'b0};
    end
  end

  assign bit_out = sh_q[7];

  // R5
  load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_len |-> !ld_pay);

endmodule

// File: rtl/pkt_field_seq.sv
module pkt_field_seq
  import framer_pkg::*;
#(
  parameter int MAX_PAY = 16,
  parameter int CNT_W   = 8,
  parameter int LEN_W   = 5,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_data,
  input  logic              start_ack,
  input  logic [CNT_W-1:0]  cfg_pre_units,
  input  logic [CNT_W-1:0]  cfg_unit_beats,
  input  logic [CNT_W-1:0]  cfg_sop_short,
  input  logic [CNT_W-1:0]  cfg_sop_long,
  input  logic              cfg_sop_sel,
  input  logic              cfg_len_en,
  input  logic [LEN_W-1:0]  pay_len,
  input  logic              hs,
  output fld_e              fld,
  output logic              beat_odd,
  output logic              frame_start,
  output logic              frame_end,
  output logic              ld_len,
  output logic              ld_pay,
  output logic [7:0]        len_val,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);

  localparam int BC_W = (CNT_W > 4) ? CNT_W : 4;
  localparam logic [LEN_W-1:0] PAY_MAX = LEN_W'(MAX_PAY);

  fld_e             st, nxt, after_sop, after_len;
  logic [BC_W-1:0]  cnt;
  logic [CNT_W-1:0] unit, units_m1, ub_m1, sop_m1;
  logic [LEN_W-1:0] plen, byte_idx, plen_in;
  logic             ack_q, len_en_q;
  logic             last, unit_end, byte_end, enter;

  assign plen_in     = (pay_len > PAY_MAX) ? PAY_MAX : pay_len;
  assign frame_start = (st == K_IDLE) && (start_data || start_ack);

  assign unit_end  = (cnt == BC_W'(ub_m1));
  assign byte_end  = (cnt[2:0] == 3'd7);
  assign after_len = (plen != '0) ? K_PAY : K_CRC;
  assign after_sop = ack_q ? K_CRC : (len_en_q ? K_LEN : after_len);

  always_comb begin
    last = 1'b0;
    nxt  = K_IDLE;
    unique case (st)
      K_PRE:  begin last = unit_end && (unit == units_m1); nxt = K_SOP1; end
      K_SOP1: begin last = (cnt == BC_W'(sop_m1)); nxt = K_SOP2; end
      K_SOP2: begin last = (cnt == BC_W'(sop_m1)); nxt = after_sop; end
      K_LEN:  begin last = byte_end; nxt = after_len; end
      K_PAY:  begin last = byte_end && ((byte_idx + LEN_W'(1)) == plen); nxt = K_CRC; end
      K_CRC:  begin last = (cnt == BC_W'(15)); nxt = K_IDLE; end
      default: begin last = 1'b0; nxt = K_IDLE; end
    endcase
  end

  assign enter     = hs && last;
  assign frame_end = enter && (st == K_CRC);
  assign ld_len    = enter && (nxt == K_LEN);
  assign ld_pay    = hs && ((last && (nxt == K_PAY)) ||
                            ((st == K_PAY) && byte_end && !last));
  assign rd_en     = ld_pay;
  assign rd_addr   = (st == K_PAY) ? ADDR_W'(byte_idx + LEN_W'(1)) : '0;
  assign len_val   = 8'(plen);
  assign fld       = st;
  assign beat_odd  = cnt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= K_IDLE;
      cnt      <= '0;
      unit     <= '0;
      units_m1 <= '0;
      ub_m1    <= '0;
      sop_m1   <= '0;
      plen     <= '0;
      byte_idx <= '0;
      ack_q    <= 1'b0;
      len_en_q <= 1'b0;
    end else if (frame_start) begin
      st       <= (cfg_pre_units != '0) ? K_PRE : K_SOP1;
      cnt      <= '0;
      unit     <= '0;
      byte_idx <= '0;
      ack_q    <= start_ack && !start_data;
      len_en_q <= cfg_len_en;
      plen     <= plen_in;
      units_m1 <= cfg_pre_units - 1'b1;
      ub_m1    <= (cfg_unit_beats == '0) ? '0 : cfg_unit_beats - 1'b1;
      if (cfg_sop_sel)
        sop_m1 <= (cfg_sop_long == '0) ? '0 : cfg_sop_long - 1'b1;
      else
        sop_m1 <= (cfg_sop_short == '0) ? '0 : cfg_sop_short - 1'b1;
    end else if (hs) begin
      if (last) begin
        st   <= nxt;
        cnt  <= '0;
        unit <= '0;
      end else if ((st == K_PRE) && unit_end) begin
        cnt  <= '0;
        unit <= unit + 1'b1;
      end else if ((st == K_PAY) && byte_end) begin
        cnt      <= '0;
        byte_idx <= byte_idx + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8
  ack_no_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (st != K_LEN && st != K_PAY));

  // R6
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (LEN_W'(rd_addr) < plen));

  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != K_IDLE && (start_data || start_ack)) |=> ($stable(plen) && $stable(ack_q) && $stable(sop_m1)));

  // R2
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == K_SOP2 && enter) |=> (st == K_LEN || st == K_PAY || st == K_CRC));

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import framer_pkg::*;
#(
  parameter int          MAX_PAY = 16,
  parameter int          CNT_W   = 8,
  parameter logic [15:0] POLY    = 16'h1021,
  parameter int          LEN_W   = $clog2(MAX_PAY + 1),
  parameter int          ADDR_W  = $clog2(MAX_PAY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_pre_units,
  input  logic [CNT_W-1:0]  cfg_unit_beats,
  input  logic [CNT_W-1:0]  cfg_sop_short,
  input  logic [CNT_W-1:0]  cfg_sop_long,
  input  logic              cfg_sop_sel,
  input  logic              cfg_len_en,
  input  logic [LEN_W-1:0]  pay_len,
  input  logic              start_data,
  input  logic              start_ack,
  input  logic              rx_crc_we,
  input  logic [15:0]       rx_crc_in,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              sym_valid,
  input  logic              sym_ready,
  output logic              sym_bit,
  output logic [2:0]        sym_kind,
  output logic              done
);

  fld_e        fld;
  logic        hs, beat_odd, frame_start, frame_end;
  logic        ld_len, ld_pay, ser_bit, crc_msb, body_beat;
  logic [7:0]  len_val;
  logic [15:0] rx_q, seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= '0;
    else if (rx_crc_we) rx_q <= rx_crc_in;
  end

  assign sym_valid = (fld != K_IDLE);
  assign hs        = sym_valid && sym_ready;
  assign body_beat = (fld == K_LEN) || (fld == K_PAY);
  assign seed      = (start_ack && !start_data) ? rx_q : 16'h0000;

  pkt_field_seq #(
    .MAX_PAY(MAX_PAY), .CNT_W(CNT_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_data(start_data), .start_ack(start_ack),
    .cfg_pre_units(cfg_pre_units), .cfg_unit_beats(cfg_unit_beats),
    .cfg_sop_short(cfg_sop_short), .cfg_sop_long(cfg_sop_long),
    .cfg_sop_sel(cfg_sop_sel), .cfg_len_en(cfg_len_en), .pay_len(pay_len),
    .hs(hs), .fld(fld), .beat_odd(beat_odd),
    .frame_start(frame_start), .frame_end(frame_end),
    .ld_len(ld_len), .ld_pay(ld_pay), .len_val(len_val),
    .rd_en(rd_en), .rd_addr(rd_addr)
  );

  pkt_byte_ser u_ser (
    .clk(clk), .rst_n(rst_n),
    .ld_len(ld_len), .len_val(len_val),
    .ld_pay(ld_pay), .pay_byte(rd_data),
    .shift_en(hs && body_beat), .bit_out(ser_bit)
  );

  pkt_crc16 #(.POLY(POLY)) u_crc (
    .clk(clk), .rst_n(rst_n),
    .init(frame_start), .init_val(seed),
    .absorb(hs && body_beat), .bit_in(ser_bit),
    .shift(hs && (fld == K_CRC)), .msb(crc_msb)
  );

  always_comb begin
    unique case (fld)
      K_PRE:   sym_bit = !beat_odd;
      K_SOP1:  sym_bit = 1'b1;
      K_SOP2:  sym_bit = 1'b0;
      K_LEN,
      K_PAY:   sym_bit = ser_bit;
      K_CRC:   sym_bit = crc_msb;
      default: sym_bit = 1'b0;
    endcase
  end

  assign sym_kind = 3'(fld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else done <= frame_end;
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_bit) && $stable(sym_kind)));

  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sym_valid && $past(hs && fld == K_CRC)));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/pkt_framer_test.sv
module pkt_framer_test;

  localparam int MAX_PAY = 16;
  localparam int CNT_W   = 8;
  localparam int LEN_W   = $clog2(MAX_PAY + 1);
  localparam int ADDR_W  = $clog2(MAX_PAY);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] cfg_pre_units = 8'd2, cfg_unit_beats = 8'd2;
  logic [CNT_W-1:0] cfg_sop_short = 8'd3, cfg_sop_long = 8'd5;
  logic cfg_sop_sel = 1'b0, cfg_len_en = 1'b1;
  logic [LEN_W-1:0] pay_len = '0;
  logic start_data = 1'b0, start_ack = 1'b0;
  logic rx_crc_we = 1'b0;
  logic [15:0] rx_crc_in = '0;
  logic rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0] rd_data;
  logic sym_valid, sym_ready, sym_bit, done;
  logic [2:0] sym_kind;

  logic [7:0] mem [0:MAX_PAY-1];
  assign rd_data = mem[rd_addr];

  int checks = 0, errors = 0, done_cnt = 0, ready_mode = 0, cyc = 0;
  int exp_q[$];
  int got_q[$];
  logic [15:0] rx_val = '0;

  always #2 clk = ~clk;

  pkt_framer uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_pre_units(cfg_pre_units), .cfg_unit_beats(cfg_unit_beats),
    .cfg_sop_short(cfg_sop_short), .cfg_sop_long(cfg_sop_long),
    .cfg_sop_sel(cfg_sop_sel), .cfg_len_en(cfg_len_en), .pay_len(pay_len),
    .start_data(start_data), .start_ack(start_ack),
    .rx_crc_we(rx_crc_we), .rx_crc_in(rx_crc_in),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_bit(sym_bit),
    .sym_kind(sym_kind), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // bytewise reference check value, polynomial 0x1021, seed 0
  function automatic logic [15:0] crc_bytes(input logic [7:0] b [$]);
    logic [15:0] c = 16'h0000;
    foreach (b[i]) begin
      c = c ^ {b[i], 8'h00};
      for (int k = 0; k < 8; k++)
        c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  function automatic int eff(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic build_exp(input bit ack);
    logic [7:0] body [$];
    logic [15:0] w;
    int sopn, n;
    exp_q.delete();
    for (int u = 0; u < int'(cfg_pre_units); u++)
      for (int k = 0; k < eff(cfg_unit_beats); k++)
        exp_q.push_back(1 * 2 + ((k % 2 == 0) ? 1 : 0));
    sopn = cfg_sop_sel ? eff(cfg_sop_long) : eff(cfg_sop_short);
    for (int k = 0; k < sopn; k++) exp_q.push_back(2 * 2 + 1);
    for (int k = 0; k < sopn; k++) exp_q.push_back(3 * 2 + 0);
    if (ack) begin
      w = rx_val;
    end else begin
      n = (int'(pay_len) > MAX_PAY) ? MAX_PAY : int'(pay_len);
      if (cfg_len_en) begin
        body.push_back(8'(n));
        for (int k = 7; k >= 0; k--) exp_q.push_back(4 * 2 + int'(body[0][k]));
      end
      for (int i = 0; i < n; i++) begin
        body.push_back(mem[i]);
        for (int k = 7; k >= 0; k--) exp_q.push_back(5 * 2 + int'(mem[i][k]));
      end
      w = crc_bytes(body);
    end
    for (int k = 15; k >= 0; k--) exp_q.push_back(6 * 2 + int'(w[k]));
  endtask

  // consumer: chooses ready, records accepted beats, watches done
  always @(negedge clk) begin
    if (!rst_n) begin
      sym_ready = 1'b0;
    end else begin
      case (ready_mode)
        1: sym_ready = 1'b1;
        2: sym_ready = (($urandom % 4) == 0);
        default: sym_ready = $urandom % 2;
      endcase
      if (sym_valid && sym_ready) got_q.push_back(int'(sym_kind) * 2 + int'(sym_bit));
      if (done) begin
        done_cnt++;
        // R10 done right after last beat, valid low
        check(got_q.size() == exp_q.size() && !sym_valid, "R10 done timing",
              got_q.size(), exp_q.size());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_frame(input bit ack, input bit both, input bit perturb, input string req);
    int t = 0;
    int bad = -1;
    build_exp(ack);
    got_q.delete();
    done_cnt = 0;
    @(negedge clk);
    start_data = !ack || both;
    start_ack  = ack || both;
    @(negedge clk);
    start_data = 1'b0;
    start_ack  = 1'b0;
    if (perturb) begin
      repeat (6) @(negedge clk);
      // R11 mid-frame disturbance
      cfg_pre_units = 8'd7; cfg_unit_beats = 8'd1; cfg_sop_sel = ~cfg_sop_sel;
      cfg_len_en = ~cfg_len_en; pay_len = 5'd9;
      start_data = 1'b1; start_ack = 1'b1;
      @(negedge clk);
      start_data = 1'b0; start_ack = 1'b0;
    end
    while (done_cnt == 0 && t < 6000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    check(done_cnt == 1, {req, " done pulses"}, done_cnt, 1);
    check(got_q.size() == exp_q.size(), {req, " beat count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
    if (bad >= 0)
      check(1'b0, {req, " beat content"}, got_q[bad], exp_q[bad]);
    else
      check(1'b1, req, 0, 0);
  endtask

  task automatic fill_mem();
    for (int i = 0; i < MAX_PAY; i++) mem[i] = 8'($urandom);
  endtask

  task automatic write_rx(input logic [15:0] v);
    @(negedge clk);
    rx_crc_we = 1'b1; rx_crc_in = v; rx_val = v;
    @(negedge clk);
    rx_crc_we = 1'b0; rx_crc_in = 16'hFFFF;
  endtask

  initial begin
    void'($urandom(32'd4242));
    fill_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!sym_valid && sym_kind == 3'd0 && !done && !rd_en, "R1 reset idle",
          {sym_valid, sym_kind, done, rd_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!sym_valid && sym_kind == 3'd0, "R1 idle after reset", sym_kind, 0);

    // R2 R3 R4 R5 R6 R7 basic data frame
    cfg_pre_units = 2; cfg_unit_beats = 3; cfg_sop_short = 4; cfg_sop_long = 6;
    cfg_sop_sel = 0; cfg_len_en = 1; pay_len = 3;
    run_frame(0, 0, 0, "R2 R3 R6 R7 data frame");

    // R4 long framing, R5 no length byte
    cfg_sop_sel = 1; cfg_len_en = 0; pay_len = 5;
    run_frame(0, 0, 0, "R4 R5 long sop no length");

    // R3 zero preamble, R12 empty payload with length
    cfg_pre_units = 0; cfg_len_en = 1; pay_len = 0; cfg_sop_sel = 0;
    run_frame(0, 0, 0, "R3 R12 no preamble empty payload");

    // R12 empty payload without length: check value 0000
    cfg_pre_units = 1; cfg_len_en = 0; pay_len = 0;
    run_frame(0, 0, 0, "R12 empty no length");

    // R3 zero beat count treated as one
    cfg_pre_units = 3; cfg_unit_beats = 0; cfg_len_en = 1; pay_len = 2;
    run_frame(0, 0, 0, "R3 zero unit beats");

    // R8 acknowledge frames
    cfg_unit_beats = 2;
    write_rx(16'hA5C3);
    run_frame(1, 0, 0, "R8 ack frame");
    write_rx(16'h0001);
    cfg_sop_sel = 1;
    run_frame(1, 0, 0, "R8 ack frame long sop");

    // R11 both starts -> data
    cfg_sop_sel = 0; pay_len = 4;
    run_frame(0, 1, 0, "R11 both starts data wins");

    // R11 disturbance during frame
    pay_len = 6; cfg_len_en = 1; cfg_pre_units = 2;
    run_frame(0, 0, 1, "R11 mid-frame changes ignored");

    // R9 full payload under each ready density, R5 clamp
    cfg_pre_units = 2; cfg_unit_beats = 2; cfg_len_en = 1; pay_len = 5'd16;
    for (int m = 0; m < 3; m++) begin
      ready_mode = m;
      run_frame(0, 0, 0, "R9 max payload stall pattern");
    end
    pay_len = 5'd20;
    run_frame(0, 0, 0, "R5 length clamp");

    // random mix
    for (int r = 0; r < 24; r++) begin
      fill_mem();
      ready_mode = $urandom % 3;
      cfg_pre_units = 8'($urandom % 4);
      cfg_unit_beats = 8'(1 + $urandom % 4);
      cfg_sop_short = 8'(1 + $urandom % 4);
      cfg_sop_long = 8'(2 + $urandom % 6);
      cfg_sop_sel = $urandom % 2;
      cfg_len_en = $urandom % 2;
      pay_len = 5'($urandom % 17);
      if ($urandom % 4 == 0) begin
        write_rx(16'($urandom));
        run_frame(1, 0, 0, "R8 random ack");
      end else begin
        run_frame(0, 0, r % 5 == 0, "R2 R7 R9 random data");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule